// File: doc/BRIEF.md
# Low-Frequency Reader Sample Front End

This block is the digital side of a low-frequency RFID reader. It runs from one main clock (nominally 24 MHz) and uses a single divider chain to produce three timing signals: a serial bit clock, the coil-drive carrier and the converter sample clock, which runs in step with the carrier. A frequency selector picks a 125 kHz or a roughly 136 kHz carrier. A programmable mode instead sets the carrier period from an 8-bit divisor.

In each carrier period the block latches one 8-bit converter sample. In the following period it shifts that sample out to a host processor, most significant bit first, over a three-wire synchronous link: a frame strobe, a data line and a bit clock. Data changes only on falling bit-clock edges, so the host samples on rising edges. The high-frequency drive output is held low, and a debug output repeats the sample clock.

Top module: `lfr_frontend`

## Requirements
- R1: While `rst` is high, and in the first cycle after any clock edge at which it was high, `ser_frame_o`, `ser_data_o` and `ser_clk_o` are low.
- R2: In fixed mode (`prog_en_i`=0) the carrier period is 16*(11+`sel_125_i`) main cycles: 192 for `sel_125_i`=1 and 176 for `sel_125_i`=0. `coil_drive_o` is high for the first half of each period and low for the second half.
- R3: In fixed mode `ser_clk_o` has a half period of 11+`sel_125_i` main cycles and completes exactly 8 cycles per carrier period, so the carrier is the bit clock divided by 8.
- R4: `adc_clk_o` is always the complement of `coil_drive_o`, so it rises at mid-period. `dbg_o` always equals `adc_clk_o`. `hf_drive_o` is always low.
- R5: The value on `adc_data_i` in the cycle before `adc_clk_o` rises is captured. It is sent in the next carrier period, one bit per rising edge of `ser_clk_o`, bit 7 first. `ser_data_o` never changes at a rising edge of `ser_clk_o`.
- R6: After reset is released, frame and bit clock stay low for one whole carrier period. `ser_frame_o` first rises 16*(11+`sel_125_i`) cycles after release in fixed mode, and stays high continuously from then on in fixed mode.
- R7: In programmable mode (`prog_en_i`=1) the carrier period is 2*(`car_div_i`+1) main cycles. The bit clock has a half period of 2 cycles. The frame is high for the first 32 cycles of each period. After that, frame, data and bit clock stay low until the period ends.
- R8: In programmable mode a divisor below 16 acts as 16, giving a 34-cycle period.
- R9: Changes to `sel_125_i`, `prog_en_i` or `car_div_i` do not alter the carrier period in progress. The new ratio applies from the next period boundary, which is the rising edge of `coil_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_125_i | input | 1 | Fixed-mode select: 1 gives 125 kHz, 0 gives about 136 kHz |
| prog_en_i | input | 1 | 1 selects the divisor-programmed carrier |
| car_div_i | input | 8 | Carrier divisor for programmable mode |
| adc_data_i | input | 8 | Parallel sample from the converter |
| coil_drive_o | output | 1 | Carrier square wave to the coil driver |
| adc_clk_o | output | 1 | Converter sample clock |
| ser_frame_o | output | 1 | Frame strobe, high while sample bits are shifted |
| ser_data_o | output | 1 | Serial sample data, MSB first |
| ser_clk_o | output | 1 | Serial bit clock |
| hf_drive_o | output | 1 | High-frequency drive, held low |
| dbg_o | output | 1 | Copy of the converter sample clock |

## Verification
On every cycle the assertions check four things: the bit counter never runs past one sample, the bit clock stays idle when no frame is active, data holds steady across each rising bit-clock edge, and the latched period length changes only at a boundary. The assertions also check that the period never falls below the floor, and that reset silences the link. Only the bench's scenarios can show the actual period lengths, the duty cycle, the bit-clock half period, the bit order of the received sample, the one-period delay of the first frame, and the fact that a ratio change mid-period leaves that period's length untouched.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

   // How the carrier length for the next period is chosen.
   typedef enum logic {
      CAR_FIXED = 1'b0,
      CAR_PROG  = 1'b1
   } car_mode_e;

   function automatic int unsigned lfr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lfr_timebase.sv
// Carrier-period counter. Latches the period length and the half-bit length at
// each boundary and decodes the carrier, sample clock and capture strobe.
module lfr_timebase
   import lfr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned BASE_HALF   = 11,
   parameter int unsigned DIV_HALF    = 2,
   parameter int unsigned DIV_MIN     = 16,
   parameter bit          PROG_DIV_EN = 1'b1,
   parameter int unsigned QW          = 9,
   parameter int unsigned HBW         = 4,
   localparam int unsigned PHW        = QW + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_i,
   input  logic             prog_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             start_o,
   output logic             cap_o,
   output logic [HBW-1:0]   hb_o,
   output logic             coil_o,
   output logic             adc_o
);

   logic [PHW-1:0] ph;
   logic [QW-1:0]  q_half;
   logic [HBW-1:0] hb;
   logic [QW-1:0]  q_nxt;
   logic [HBW-1:0] hb_nxt;
   logic [HBW-1:0] hb_fix;
   logic [QW-1:0]  q_fix;
   logic [PHW-1:0] ph_last;
   logic [PHW-1:0] ph_mid;

   assign hb_fix = HBW'(BASE_HALF) + HBW'(sel_i);
   assign q_fix  = QW'(DATA_W) * QW'(hb_fix);

   generate
      if (PROG_DIV_EN) begin : g_prog
         car_mode_e      mode;
         logic [DIV_W-1:0] div_eff;
         assign mode    = prog_i ? CAR_PROG : CAR_FIXED;
         assign div_eff = (div_i < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_i;
         always_comb begin
            if (mode == CAR_PROG) begin
               q_nxt  = QW'(div_eff) + QW'(1);
               hb_nxt = HBW'(DIV_HALF);
            end else begin
               q_nxt  = q_fix;
               hb_nxt = hb_fix;
            end
         end
      end else begin : g_fixed
         assign q_nxt  = q_fix;
         assign hb_nxt = hb_fix;
      end
   endgenerate

   assign ph_last = {q_half, 1'b0} - PHW'(1);
   assign ph_mid  = {1'b0, q_half};
   assign start_o = (ph == ph_last);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph     <= '0;
         q_half <= q_nxt;
         hb     <= hb_nxt;
      end else if (start_o) begin
         ph     <= '0;
         q_half <= q_nxt;
         hb     <= hb_nxt;
      end else begin
         ph <= ph + PHW'(1);
      end
   end

   assign coil_o = (ph < ph_mid);
   assign adc_o  = ~coil_o;
   assign cap_o  = (ph == ph_mid - PHW'(1));
   assign hb_o   = hb;

   // R9: period and half-bit lengths move only at a boundary
   a_r9_len_held: assert property (@(posedge clk) disable iff (rst)
      !start_o |=> ($stable(q_half) && $stable(hb)));

   // R8: the latched half period never falls below the floor
   a_r8_div_floor: assert property (@(posedge clk) disable iff (rst)
      q_half >= QW'(DIV_MIN + 1));

endmodule

// File: rtl/lfr_bitclk.sv
// Serial bit clock: restarts at every carrier boundary, runs DATA_W full
// cycles, then idles low until the next boundary.
module lfr_bitclk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HBW    = 4,
   localparam int unsigned CW    = $clog2(DATA_W + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start_i,
   input  logic [HBW-1:0] hb_i,
   output logic           sclk_o,
   output logic           fall_o,
   output logic           active_o
);

   logic [HBW-1:0] hcnt;
   logic [CW-1:0]  bitcnt;
   logic           sclk_r;
   logic           half_end;

   assign active_o = (bitcnt < CW'(DATA_W));
   assign half_end = (hcnt == hb_i - HBW'(1));
   assign fall_o   = active_o && half_end && sclk_r;
   assign sclk_o   = sclk_r;

   always_ff @(posedge clk) begin
      if (rst || start_i) begin
         hcnt   <= '0;
         sclk_r <= 1'b0;
         bitcnt <= '0;
      end else if (active_o) begin
         if (half_end) begin
            hcnt   <= '0;
            sclk_r <= ~sclk_r;
            if (sclk_r) bitcnt <= bitcnt + CW'(1);
         end else begin
            hcnt <= hcnt + HBW'(1);
         end
      end
   end

   // R3: never more than one sample's worth of bits per period
   a_r3_bit_cap: assert property (@(posedge clk) disable iff (rst)
      bitcnt <= CW'(DATA_W));

endmodule

// File: rtl/lfr_shifter.sv
// Sample capture and MSB-first shift register; a captured sample is sent in
// the period after the one in which it was taken.
module lfr_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              cap_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              primed_o,
   output logic              msb_o
);

   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] sh;
   logic              primed;

   always_ff @(posedge clk) begin
      if (rst) begin
         held   <= '0;
         sh     <= '0;
         primed <= 1'b0;
      end else begin
         if (cap_i) held <= sample_i;
         if (start_i) begin
            sh     <= held;
            primed <= 1'b1;
         end else if (shift_i) begin
            sh <= {sh[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign primed_o = primed;
   assign msb_o    = sh[DATA_W-1];

endmodule

// File: rtl/lfr_frontend.sv
// Top: one divider chain feeding carrier, sample clock and serial link.
module lfr_frontend
   import lfr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned BASE_HALF   = 11,
   parameter int unsigned DIV_HALF    = 2,
   parameter int unsigned DIV_MIN     = 16,
   parameter bit          PROG_DIV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_125_i,
   input  logic              prog_en_i,
   input  logic [DIV_W-1:0]  car_div_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              coil_drive_o,
   output logic              adc_clk_o,
   output logic              ser_frame_o,
   output logic              ser_data_o,
   output logic              ser_clk_o,
   output logic              hf_drive_o,
   output logic              dbg_o
);

   localparam int unsigned HB_MAX = lfr_max(BASE_HALF + 1, DIV_HALF);
   localparam int unsigned Q_MAX  = lfr_max(DATA_W * (BASE_HALF + 1), 2 ** DIV_W);
   localparam int unsigned HBW    = $clog2(HB_MAX + 1);
   localparam int unsigned QW     = $clog2(Q_MAX + 1);

   generate
      if (DATA_W < 2) begin : g_chk_w
         $error("DATA_W must be at least 2");
      end
      if (BASE_HALF < 1 || DIV_HALF < 1) begin : g_chk_h
         $error("half-bit lengths must be nonzero");
      end
      if (DIV_MIN + 1 < DIV_HALF * DATA_W) begin : g_chk_fit
         $error("DIV_MIN too small for a full frame in one period");
      end
      if (DIV_MIN >= 2 ** DIV_W) begin : g_chk_min
         $error("DIV_MIN does not fit in DIV_W bits");
      end
   endgenerate

   logic           start;
   logic           cap;
   logic [HBW-1:0] hb;
   logic           sclk;
   logic           fall;
   logic           active;
   logic           primed;
   logic           msb;

   lfr_timebase #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .BASE_HALF(BASE_HALF), .DIV_HALF(DIV_HALF),
      .DIV_MIN(DIV_MIN), .PROG_DIV_EN(PROG_DIV_EN), .QW(QW), .HBW(HBW)
   ) u_tb (
      .clk(clk), .rst(rst), .sel_i(sel_125_i), .prog_i(prog_en_i), .div_i(car_div_i),
      .start_o(start), .cap_o(cap), .hb_o(hb), .coil_o(coil_drive_o), .adc_o(adc_clk_o)
   );

   lfr_bitclk #(.DATA_W(DATA_W), .HBW(HBW)) u_bc (
      .clk(clk), .rst(rst), .start_i(start), .hb_i(hb),
      .sclk_o(sclk), .fall_o(fall), .active_o(active)
   );

   lfr_shifter #(.DATA_W(DATA_W)) u_sh (
      .clk(clk), .rst(rst), .start_i(start), .cap_i(cap), .shift_i(fall),
      .sample_i(adc_data_i), .primed_o(primed), .msb_o(msb)
   );

   assign ser_frame_o = primed && active;
   assign ser_data_o  = ser_frame_o && msb;
   assign ser_clk_o   = primed && sclk;
   assign hf_drive_o  = 1'b0;
   assign dbg_o       = adc_clk_o;

   // R1: a reset edge silences the link on the following cycle
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!ser_frame_o && !ser_data_o && !ser_clk_o));

   // R5: data is steady across each rising bit-clock edge inside a frame
   a_r5_data_on_fall: assert property (@(posedge clk) disable iff (rst)
      ($rose(ser_clk_o) && $past(ser_frame_o)) |-> $stable(ser_data_o));

   // R7: the bit clock is idle whenever no frame is active
   a_r7_sclk_idle: assert property (@(posedge clk) disable iff (rst)
      !ser_frame_o |-> !ser_clk_o);

endmodule

// File: tb/lfr_frontend_bench.sv
module lfr_frontend_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sel = 1'b1;
   logic       prog = 1'b0;
   logic [7:0] cdiv = 8'd0;
   logic [7:0] adc = 8'd0;
   logic coil_drive_o, adc_clk_o, ser_frame_o, ser_data_o, ser_clk_o, hf_drive_o, dbg_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   lfr_frontend u_lfr_frontend (
      .clk(clk), .rst(rst), .sel_125_i(sel), .prog_en_i(prog), .car_div_i(cdiv),
      .adc_data_i(adc), .coil_drive_o(coil_drive_o), .adc_clk_o(adc_clk_o),
      .ser_frame_o(ser_frame_o), .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o),
      .hf_drive_o(hf_drive_o), .dbg_o(dbg_o)
   );

   typedef struct packed {
      logic        prog;
      logic        sel;
      logic [7:0]  div;
      logic [7:0]  val;
      logic [15:0] period;
      logic [7:0]  half;
      logic [15:0] frame;
   } vec_t;

   // columns: mode, select, divisor, sample, period, bit half period, frame cycles
   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b1, 8'd0,   8'hA5, 16'd192, 8'd12, 16'd192},
      '{1'b0, 1'b0, 8'd0,   8'h3C, 16'd176, 8'd11, 16'd176},
      '{1'b1, 1'b1, 8'd95,  8'h81, 16'd192, 8'd2,  16'd32},
      '{1'b1, 1'b0, 8'd16,  8'h7E, 16'd34,  8'd2,  16'd32},
      '{1'b1, 1'b0, 8'd3,   8'hC3, 16'd34,  8'd2,  16'd32},
      '{1'b1, 1'b1, 8'd255, 8'h01, 16'd512, 8'd2,  16'd32}
   };

   int         m_len, m_hi, m_frame, m_rises, m_shi, m_mis;
   logic [7:0] m_byte;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_rise();
      logic pc;
      pc = coil_drive_o;
      forever begin
         @(negedge clk);
         if (coil_drive_o && !pc) break;
         pc = coil_drive_o;
      end
   endtask

   // Called at the negedge where the carrier has just risen; runs one period.
   task automatic measure(input int chg_at, input logic chg_sel);
      logic pc, ps;
      int   run;
      pc = 1'b1; ps = 1'b0; run = 0;
      m_len = 0; m_hi = 0; m_frame = 0; m_rises = 0; m_shi = 0; m_mis = 0; m_byte = '0;
      forever begin
         if (coil_drive_o) m_hi++;
         if (adc_clk_o !== ~coil_drive_o || dbg_o !== adc_clk_o || hf_drive_o !== 1'b0) m_mis++;
         if (ser_frame_o) m_frame++;
         if (ser_clk_o && !ps) begin
            if (ser_frame_o) begin
               m_byte = {m_byte[6:0], ser_data_o};
               m_rises++;
            end
            run = 0;
         end
         if (ser_clk_o) run++;
         if (!ser_clk_o && ps && m_shi == 0) m_shi = run;
         ps = ser_clk_o;
         pc = coil_drive_o;
         m_len++;
         if (m_len == chg_at) sel = chg_sel;
         @(negedge clk);
         if (coil_drive_o && !pc) break;
         if (m_len > 4000) break;
      end
   endtask

   initial begin
      // watchdog
      #2000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int k;
      int first;
      logic bad_clk;
      // reset state (R1, R4)
      repeat (4) @(negedge clk);
      chk("R1", "frame in reset", ser_frame_o, 0);
      chk("R1", "data in reset", ser_data_o, 0);
      chk("R1", "sclk in reset", ser_clk_o, 0);
      chk("R4", "hf drive low", hf_drive_o, 0);
      chk("R4", "dbg mirrors adc clk", dbg_o, adc_clk_o);

      // first frame after release (R6)
      adc = 8'h5A;
      rst = 1'b0;
      first = 0; bad_clk = 1'b0;
      for (k = 1; k <= 400; k++) begin
         @(negedge clk);
         if (ser_frame_o) begin first = k; break; end
         if (ser_clk_o) bad_clk = 1'b1;
      end
      chk("R6", "first frame delay", first, 192);
      chk("R6", "sclk idle before first frame", bad_clk, 0);

      // table of configurations (R2 R3 R4 R5 R6 R7 R8)
      for (int i = 0; i < 6; i++) begin
         prog = VECS[i].prog;
         sel  = VECS[i].sel;
         cdiv = VECS[i].div;
         adc  = VECS[i].val;
         wait_rise();
         wait_rise();
         measure(-1, VECS[i].sel);
         chk(VECS[i].prog ? (VECS[i].div < 16 ? "R8" : "R7") : "R2", "period", m_len, VECS[i].period);
         chk("R2", "carrier high half", m_hi, VECS[i].period / 2);
         chk("R3", "sclk half period", m_shi, VECS[i].half);
         chk("R3", "bits per period", m_rises, 8);
         chk("R5", "received sample MSB first", m_byte, VECS[i].val);
         chk(VECS[i].prog ? "R7" : "R6", "frame high cycles", m_frame, VECS[i].frame);
         chk("R4", "adc/dbg/hf relation mismatches", m_mis, 0);
      end

      // ratio change mid-period takes effect at the next boundary (R9)
      prog = 1'b0; sel = 1'b1;
      wait_rise();
      wait_rise();
      measure(50, 1'b0);
      chk("R9", "period in progress keeps old length", m_len, 192);
      measure(-1, 1'b0);
      chk("R9", "next period uses new length", m_len, 176);

      // reset in mid-operation (R1)
      repeat (37) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "frame after mid-run reset", ser_frame_o, 0);
      chk("R1", "sclk after mid-run reset", ser_clk_o, 0);
      chk("R1", "data after mid-run reset", ser_data_o, 0);
      @(negedge clk);
      rst = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule